// File: doc/BRIEF.md
# Switch Debouncer with Press Tick

This block filters a single bouncing switch level so that logic downstream sees only clean transitions. A four-state controller tracks whether the debounced level is low or high. It also tracks whether a change of the raw input is being confirmed. A separate down-counter measures the confirmation interval. The controller drives the counter only through a load strobe and a decrement strobe, carried in a small struct. The counter reports back whether its next value will be zero.

The debounced level changes only after the raw input has held its new value for a full interval of 2^CNT_W consecutive samples. For each confirmed press, a one-cycle tick is raised in the same cycle that the last sample of the rising interval is taken. The controller tests the counter's next value, not its registered value, against zero. This lets the tick fire in the cycle where the count expires and keeps each interval to exactly 2^CNT_W cycles. Any sample of the old value during confirmation abandons it, and the next attempt restarts the full interval.

Top module: `switch_debounce`

## Requirements
- R1: An asynchronous active-high reset, applied at any time (including mid-confirmation), forces swLevel and swTick to 0 and clears the counter. After release, a full interval is needed before a rise is accepted.
- R2: While swLevel is 0, once swRaw has been sampled high on 2^CNT_W consecutive rising clock edges (16 with the default CNT_W of 4), swLevel becomes 1 at the edge that takes the last of those samples. With one fewer high sample, swLevel stays 0.
- R3: swTick is 1 for exactly one cycle per confirmed rise. That cycle is the one whose closing edge takes the 2^CNT_W-th high sample, and swLevel is still 0 during it.
- R4: While a rise is being confirmed, a single low sample of swRaw abandons it with no tick and no level change. The next high sample starts a fresh full interval of 2^CNT_W samples.
- R5: While swLevel is 1, swLevel becomes 0 at the edge that takes the 2^CNT_W-th consecutive low sample of swRaw, and no tick is raised for the fall.
- R6: While a fall is being confirmed, a single high sample of swRaw abandons it. swLevel stays 1, and the next low sample starts a fresh full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| swRaw | input | 1 | Raw switch level, assumed already synchronous to clk |
| swLevel | output | 1 | Debounced switch level |
| swTick | output | 1 | One-cycle pulse on each confirmed rising edge |

## Verification
Clean presses and releases held well beyond the interval show the basic level following and the single press tick. Presses held for exactly 2^CNT_W samples and for one sample fewer separate a correct next-value zero test from one that uses the registered count, which would add a cycle. Bursts of short bounces on both edges, with single opposite samples placed late in the count, show that each abort reloads the full interval. A reset applied in the middle of a rise confirmation shows that no partial count survives.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  // Controller states: settled low, confirming a rise, settled high,
  // confirming a fall.
  typedef enum logic [1:0] {
    ST_LOW       = 2'd0,
    ST_RISE_WAIT = 2'd1,
    ST_HIGH      = 2'd2,
    ST_FALL_WAIT = 2'd3
  } dbState_e;

  // Strobes from the controller to the interval counter.
  typedef struct packed {
    logic load;  // reload the counter with all ones
    logic dec;   // count down by one
  } cntStrobe_t;

endpackage

// File: rtl/debounce_count.sv
module debounce_count
  import debounce_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrobe_t       strobe,
  output logic             nextIsZero
);

  localparam logic [CNT_W-1:0] LOAD_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE_VAL  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countNext;

  // Next value: hold by default, so no latch and no surprise updates.
  always_comb begin
    countNext = countQ;
    if (strobe.load) begin
      countNext = LOAD_VAL;
    end else if (strobe.dec) begin
      countNext = countQ - ONE_VAL;
    end
  end

  // The zero test is on the next value, so expiry is seen this cycle.
  assign nextIsZero = (countNext == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      countQ <= '0;
    end else begin
      countQ <= countNext;
    end
  end

endmodule

// File: rtl/debounce_ctrl.sv
module debounce_ctrl
  import debounce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       swRaw,
  input  logic       nextIsZero,
  output cntStrobe_t strobe,
  output logic       levelOut,
  output logic       tickOut
);

  dbState_e stateQ;
  dbState_e stateNext;

  // Counter strobes depend only on state and input, never on the
  // counter's answer, so the datapath round trip stays acyclic.
  always_comb begin
    strobe = '0;
    unique case (stateQ)
      ST_LOW:       strobe.load = swRaw;
      ST_RISE_WAIT: strobe.dec  = swRaw;
      ST_HIGH:      strobe.load = ~swRaw;
      ST_FALL_WAIT: strobe.dec  = ~swRaw;
      default:      strobe = '0;
    endcase
  end

  // Transitions and the press tick: sample, count and compare all in
  // the same cycle of a single state.
  always_comb begin
    stateNext = stateQ;
    tickOut   = 1'b0;
    unique case (stateQ)
      ST_LOW: begin
        if (swRaw) stateNext = ST_RISE_WAIT;
      end
      ST_RISE_WAIT: begin
        if (!swRaw) begin
          stateNext = ST_LOW;
        end else if (nextIsZero) begin
          tickOut   = 1'b1;
          stateNext = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (!swRaw) stateNext = ST_FALL_WAIT;
      end
      ST_FALL_WAIT: begin
        if (swRaw) begin
          stateNext = ST_HIGH;
        end else if (nextIsZero) begin
          stateNext = ST_LOW;
        end
      end
      default: stateNext = ST_LOW;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateQ <= ST_LOW;
    end else begin
      stateQ <= stateNext;
    end
  end

  assign levelOut = (stateQ == ST_HIGH) || (stateQ == ST_FALL_WAIT);

endmodule

// File: rtl/switch_debounce.sv
module switch_debounce
  import debounce_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic swRaw,
  output logic swLevel,
  output logic swTick
);

  cntStrobe_t cntStrobe;
  logic       cntNextZero;

  debounce_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .swRaw      (swRaw),
    .nextIsZero (cntNextZero),
    .strobe     (cntStrobe),
    .levelOut   (swLevel),
    .tickOut    (swTick)
  );

  debounce_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .strobe     (cntStrobe),
    .nextIsZero (cntNextZero)
  );

endmodule

// File: rtl/debounce_checker.sv
module debounce_checker (
  input logic clk,
  input logic rst,
  input logic swRaw,
  input logic swLevel,
  input logic swTick
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> (!swLevel && !swTick)); // R1

  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(swLevel) |-> $past(swTick)); // R2

  AST_TICK_RAISES_LEVEL: assert property (@(posedge clk) disable iff (rst)
    swTick |=> swLevel); // R2

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    swTick |=> !swTick); // R3

  AST_TICK_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    swTick |-> !swLevel); // R3

  AST_TICK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    swTick |-> swRaw); // R4

  AST_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(swLevel) |-> !$past(swRaw)); // R5

  AST_RISE_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(swLevel) |-> $past(swRaw)); // R6

endmodule

bind switch_debounce debounce_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .swRaw   (swRaw),
  .swLevel (swLevel),
  .swTick  (swTick)
);

// File: tb/tb_switch_debounce.sv
module tb_switch_debounce;

  localparam int CNT_W    = 4;
  localparam int INTERVAL = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swRaw = 1'b0;
  logic swLevel;
  logic swTick;

  int checks   = 0;
  int failures = 0;

  // Reference state: debounced level and length of the current run of
  // samples that disagree with it.
  int refLevel = 0;
  int refRun   = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  switch_debounce #(.CNT_W(CNT_W)) dut (
    .clk     (clk),
    .rst     (rst),
    .swRaw   (swRaw),
    .swLevel (swLevel),
    .swTick  (swTick)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare, advance the model to
  // what the next rising edge should produce.
  task automatic step(input logic val, input logic rstVal);
    int expTick;
    @(negedge clk);
    swRaw = val;
    rst   = rstVal;
    #1;
    expTick = 0;
    if (rst) begin
      refLevel = 0;
      refRun   = 0;
      check("R1", "level", int'(swLevel), 0);
      check("R1", "tick", int'(swTick), 0);
    end else begin
      if ((val ? 1 : 0) != refLevel) refRun++;
      else refRun = 0;
      if (refLevel == 0 && refRun == INTERVAL) expTick = 1;
      check(phase, "level", int'(swLevel), refLevel);
      check((expTick != 0 || swTick) ? "R3" : phase, "tick", int'(swTick), expTick);
      if (refRun == INTERVAL) begin
        refLevel = 1 - refLevel;
        refRun   = 0;
      end
    end
  endtask

  task automatic hold(input logic val, input int n);
    for (int i = 0; i < n; i++) step(val, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    // R1: reset state with the input wiggling.
    phase = "R1";
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    hold(1'b0, 3);

    // R2: clean press, then R5 clean release.
    phase = "R2";
    hold(1'b1, INTERVAL + 6);
    phase = "R5";
    hold(1'b0, INTERVAL + 6);

    // R2: one sample short of the interval, no rise.
    phase = "R2";
    hold(1'b1, INTERVAL - 1);
    hold(1'b0, 3);
    // R2/R3: exactly the interval, tick on the last sample.
    hold(1'b1, INTERVAL);
    hold(1'b0, 1);
    hold(1'b1, 4);

    // R5: release one short, then exactly the interval.
    phase = "R5";
    hold(1'b0, INTERVAL - 1);
    hold(1'b1, 2);
    hold(1'b0, INTERVAL);
    hold(1'b0, 3);

    // R4: rising bounces, including an abort on the last sample.
    phase = "R4";
    hold(1'b1, 3);  hold(1'b0, 1);
    hold(1'b1, 7);  hold(1'b0, 2);
    hold(1'b1, INTERVAL - 1); hold(1'b0, 1);
    hold(1'b1, 1);  hold(1'b0, 1);
    hold(1'b1, INTERVAL + 2);

    // R6: falling bounces, including an abort on the last sample.
    phase = "R6";
    hold(1'b0, 5);  hold(1'b1, 1);
    hold(1'b0, INTERVAL - 1); hold(1'b1, 1);
    hold(1'b0, 2);  hold(1'b1, 3);
    hold(1'b0, INTERVAL + 2);

    // R1: reset in the middle of a rise confirmation.
    phase = "R1";
    hold(1'b1, 9);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    hold(1'b1, INTERVAL + 3);
    hold(1'b0, INTERVAL + 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule